// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits between a pulse-width modulator's action stage and the gate drivers of a half bridge. It takes the two raw PWM levels and turns them into a pair of gate signals in which a rising edge, a falling edge, or both are held back by a programmed number of time-base ticks. Holding back the turn-on edge of each switch leaves a gap in which neither switch conducts. The block counts in time-base ticks only, which are cycles of `clk` with `tb_ce` high.

Two select bits route either raw input into the rising-edge delay path and into the falling-edge delay path. A two-bit polarity field can invert either delayed path. A two-bit bypass field can replace either output with its raw input, so either delay or both delays can be removed. With both sources on input A, output B inverted and no bypass, the pair is complementary, with a dead band on each transition.

Top module: `pwm_deadband`

## Requirements
- R1: A synchronous active-high reset drives both gate outputs to 0 and clears all delay state.
- R2: The rising-edge delay path follows its source, but its rise comes `rise_dly_i` ticks later than with a delay of 0. It falls on the first tick its source is sampled low.
- R3: The falling-edge delay path follows its source, but its fall comes `fall_dly_i` ticks later than with a delay of 0. It rises on the first tick its source is sampled high.
- R4: A source pulse of L ticks, with L less than or equal to the delay, leaves no pulse on the delayed path. A longer pulse leaves a pulse of L minus the delay ticks.
- R5: A delay value of 0 gives the same timing as bypass: each output shows the value sampled at one tick after the next tick.
- R6: `rise_src_i` = 0 feeds the rising path from `pwm_a_i` and 1 feeds it from `pwm_b_i`. `fall_src_i` selects the falling path's source with the same encoding.
- R7: `pol_i` bit 0 inverts the rising path before `gate_a_o` and bit 1 inverts the falling path before `gate_b_o`, so 00 inverts neither, 01 inverts A, 10 inverts B and 11 inverts both.
- R8: `bypass_i` bit 0 set makes `gate_a_o` show raw `pwm_a_i` and bit 1 set makes `gate_b_o` show raw `pwm_b_i`, each one tick after the sample. Both bits set pass both inputs through unchanged.
- R9: With `tb_ce` low, the inputs are ignored, the outputs hold and delay progress stops.
- R10: In complementary mode (both sources 0, `pol_i` = 10, `bypass_i` = 00) the two gate outputs are never high together.
- R11: The largest delay value (1023 for 10-bit fields) works without wrapping: a 1023-tick pulse is absorbed and a 1030-tick pulse leaves 7 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_ce | input | 1 | Time-base tick enable |
| pwm_a_i | input | 1 | Raw PWM level A |
| pwm_b_i | input | 1 | Raw PWM level B |
| rise_src_i | input | 1 | Source of rising-edge path (0 = A, 1 = B) |
| fall_src_i | input | 1 | Source of falling-edge path (0 = A, 1 = B) |
| pol_i | input | 2 | Inversion: bit 0 path A, bit 1 path B |
| bypass_i | input | 2 | Bypass: bit 0 output A, bit 1 output B |
| rise_dly_i | input | DLY_W | Rising-edge delay in ticks |
| fall_dly_i | input | DLY_W | Falling-edge delay in ticks |
| gate_a_o | output | 1 | Gate drive A |
| gate_b_o | output | 1 | Gate drive B |

## Verification
The bench builds the block with its default 10-bit delay fields. At that width the full delay range can be reached, so a run at delay 1023 with pulses just under and just over the limit shows that the tick counters saturate and do not wrap. Short delays from 0 to 5 cover the absorb and pass cases, every source, polarity and bypass code, and gaps with the tick enable low. A behavioural run-length model predicts each tick's output pair.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_sel_e;
  localparam int PATH_RISE = 0;
  localparam int PATH_FALL = 1;
  localparam int NUM_PATHS = 2;
endpackage

// File: rtl/dbg_route.sv
module dbg_route
  import dbg_pkg::*;
(
  input  logic pwm_a_i,
  input  logic pwm_b_i,
  input  logic rise_src_i,
  input  logic fall_src_i,
  output logic rise_lvl_o,
  output logic fall_lvl_o
);
  always_comb begin
    rise_lvl_o = (src_sel_e'(rise_src_i) == SRC_B) ? pwm_b_i : pwm_a_i;
    fall_lvl_o = (src_sel_e'(fall_src_i) == SRC_B) ? pwm_b_i : pwm_a_i;
  end
endmodule

// File: rtl/dbg_edge_delay.sv
// Holds back the assertion of lvl_i by dly_i ticks; deassertion is immediate.
module dbg_edge_delay #(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_i,
  input  logic             lvl_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             lvl_o
);
  logic [DLY_W-1:0] run_q;
  logic             lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (ce_i) begin
      if (!lvl_i) begin
        run_q <= '0;
        lvl_q <= 1'b0;
      end else if (run_q >= dly_i) begin
        lvl_q <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;

  // R9: no progress without a tick
  a_r9_unit_hold: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> ($stable(lvl_q) && $stable(run_q)));
  // R2: a tick with the level low drops the delayed level at once
  a_r2_fast_drop: assert property (@(posedge clk) disable iff (rst)
    (ce_i && !lvl_i) |=> !lvl_q);
  // R4: the delayed level only asserts on a tick with the source asserted
  a_r4_rise_needs_src: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_q) |-> ($past(ce_i) && $past(lvl_i)));
endmodule

// File: rtl/dbg_out_stage.sv
module dbg_out_stage
  import dbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_i,
  input  logic       pwm_a_i,
  input  logic       pwm_b_i,
  input  logic       rise_dl_i,
  input  logic       fall_dl_i,
  input  logic [1:0] pol_i,
  input  logic [1:0] bypass_i,
  output logic       gate_a_o,
  output logic       gate_b_o
);
  logic raw_a_q, raw_b_q;
  logic gate_a_q, gate_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_a_q  <= 1'b0;
      raw_b_q  <= 1'b0;
      gate_a_q <= 1'b0;
      gate_b_q <= 1'b0;
    end else if (ce_i) begin
      raw_a_q  <= pwm_a_i;
      raw_b_q  <= pwm_b_i;
      gate_a_q <= bypass_i[0] ? raw_a_q : (rise_dl_i ^ pol_i[0]);
      gate_b_q <= bypass_i[1] ? raw_b_q : (fall_dl_i ^ pol_i[1]);
    end
  end

  assign gate_a_o = gate_a_q;
  assign gate_b_o = gate_b_q;

  // R9: outputs hold between ticks
  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> ($stable(gate_a_q) && $stable(gate_b_q)));
  // R8: bypass on A shows the raw level captured on the previous tick
  a_r8_bypass_a: assert property (@(posedge clk) disable iff (rst)
    (ce_i && bypass_i[0]) |=> (gate_a_q == $past(raw_a_q)));
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import dbg_pkg::*;
#(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tb_ce,
  input  logic             pwm_a_i,
  input  logic             pwm_b_i,
  input  logic             rise_src_i,
  input  logic             fall_src_i,
  input  logic [1:0]       pol_i,
  input  logic [1:0]       bypass_i,
  input  logic [DLY_W-1:0] rise_dly_i,
  input  logic [DLY_W-1:0] fall_dly_i,
  output logic             gate_a_o,
  output logic             gate_b_o
);
  logic                 rise_src_lvl, fall_src_lvl;
  logic [NUM_PATHS-1:0] path_in;
  logic [NUM_PATHS-1:0] path_out;
  logic [DLY_W-1:0]     path_dly [NUM_PATHS];

  dbg_route u_route (
    .pwm_a_i    (pwm_a_i),
    .pwm_b_i    (pwm_b_i),
    .rise_src_i (rise_src_i),
    .fall_src_i (fall_src_i),
    .rise_lvl_o (rise_src_lvl),
    .fall_lvl_o (fall_src_lvl)
  );

  // The falling path delays the assertion of the inverted source.
  assign path_in[PATH_RISE]  = rise_src_lvl;
  assign path_in[PATH_FALL]  = ~fall_src_lvl;
  assign path_dly[PATH_RISE] = rise_dly_i;
  assign path_dly[PATH_FALL] = fall_dly_i;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    dbg_edge_delay #(.DLY_W(DLY_W)) u_dly (
      .clk   (clk),
      .rst   (rst),
      .ce_i  (tb_ce),
      .lvl_i (path_in[p]),
      .dly_i (path_dly[p]),
      .lvl_o (path_out[p])
    );
  end

  dbg_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .ce_i      (tb_ce),
    .pwm_a_i   (pwm_a_i),
    .pwm_b_i   (pwm_b_i),
    .rise_dl_i (path_out[PATH_RISE]),
    .fall_dl_i (~path_out[PATH_FALL]),
    .pol_i     (pol_i),
    .bypass_i  (bypass_i),
    .gate_a_o  (gate_a_o),
    .gate_b_o  (gate_b_o)
  );

  logic comp_cfg;
  assign comp_cfg = !rise_src_i && !fall_src_i && (pol_i == 2'b10) && (bypass_i == 2'b00);

  // R10: complementary pair never overlaps
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (comp_cfg && $past(comp_cfg)) |-> !(gate_a_o && gate_b_o));
  // R1: reset clears the outputs
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!gate_a_o && !gate_b_o));
endmodule

// File: tb/pwm_deadband_test.sv
module pwm_deadband_test;
  localparam int DLY_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tb_ce = 1'b0;
  logic pwm_a = 1'b0, pwm_b = 1'b0;
  logic rsrc = 1'b0, fsrc = 1'b0;
  logic [1:0] pol = 2'b00, byp = 2'b00;
  logic [DLY_W-1:0] rdly = '0, fdly = '0;
  logic gate_a, gate_b;

  always #10 clk = ~clk;

  pwm_deadband #(.DLY_W(DLY_W)) uut (
    .clk(clk), .rst(rst), .tb_ce(tb_ce),
    .pwm_a_i(pwm_a), .pwm_b_i(pwm_b),
    .rise_src_i(rsrc), .fall_src_i(fsrc),
    .pol_i(pol), .bypass_i(byp),
    .rise_dly_i(rdly), .fall_dly_i(fdly),
    .gate_a_o(gate_a), .gate_b_o(gate_b)
  );

  typedef struct { logic a; logic b; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int hi_run = 0, lo_run = 0;
  string phase = "R1";
  bit done = 0;

  task automatic check(input logic ga, input logic gb, input logic ea, input logic eb, input string tag);
    checks++;
    if (ga !== ea || gb !== eb) begin
      fails++;
      $display("FAIL %s: gates a,b = %b,%b expected %b,%b at %0t", tag, ga, gb, ea, eb, $time);
    end
  endtask

  // Driver: one tick with the given inputs; pushes the expected pair.
  task automatic drive(input logic a, input logic b);
    exp_t it;
    logic rs, fs, red, fed;
    @(negedge clk);
    pwm_a = a; pwm_b = b; tb_ce = 1'b1;
    rs = rsrc ? b : a;
    fs = fsrc ? b : a;
    hi_run = rs ? hi_run + 1 : 0;
    lo_run = fs ? 0 : lo_run + 1;
    red = rs && (hi_run > int'(rdly));
    fed = !(!fs && (lo_run > int'(fdly)));
    it.a = byp[0] ? a : (red ^ pol[0]);
    it.b = byp[1] ? b : (fed ^ pol[1]);
    it.tag = phase;
    exp_q.push_back(it);
  endtask

  task automatic hold(input logic a, input logic b, input int n);
    for (int i = 0; i < n; i++) drive(a, b);
  endtask

  task automatic pattern(input int n, input int pa, input int pb);
    for (int i = 0; i < n; i++) drive((i % pa) < (pa / 2 + 1), (i % pb) < (pb / 2));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tb_ce = 1'b0;
      pwm_a = ~pwm_a;
      pwm_b = ~pwm_b;
    end
  endtask

  task automatic do_reset(input logic rs, input logic fs, input logic [1:0] pl,
                          input logic [1:0] bp, input int rd, input int fd);
    @(negedge clk);
    rst = 1'b1; tb_ce = 1'b0;
    rsrc = rs; fsrc = fs; pol = pl; byp = bp;
    rdly = DLY_W'(rd); fdly = DLY_W'(fd);
    exp_q.delete();
    hi_run = 0; lo_run = 0;
    @(negedge clk);
    @(negedge clk);
    check(gate_a, gate_b, 1'b0, 1'b0, "R1 reset");
    rst = 1'b0;
  endtask

  // Monitor: compares the outputs on every edge against the scoreboard.
  exp_t prev_e, cur_e;
  bit have_prev = 0, have_cur = 0;
  always @(posedge clk) begin
    logic ce_s, rst_s;
    ce_s = tb_ce; rst_s = rst;
    #5;
    if (rst_s) begin
      have_prev = 0; have_cur = 0;
    end else if (ce_s) begin
      if (have_prev) begin
        check(gate_a, gate_b, prev_e.a, prev_e.b, prev_e.tag);
        cur_e = prev_e; have_cur = 1;
      end
      if (exp_q.size() > 0) begin
        prev_e = exp_q.pop_front(); have_prev = 1;
      end
    end else if (have_cur) begin
      check(gate_a, gate_b, cur_e.a, cur_e.b, "R9 hold without tick");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R2 R3 R4: rise delay 3, fall delay 5, both from A
    phase = "R2 R3 R4 delays 3/5";
    do_reset(1'b0, 1'b0, 2'b00, 2'b00, 3, 5);
    hold(0,0,4); hold(1,0,10); hold(0,0,10); hold(1,0,2); hold(0,0,8);
    hold(1,0,3); hold(0,0,3); hold(1,0,6); hold(0,0,8);

    // R5: zero delay matches bypass timing
    phase = "R5 zero delay";
    do_reset(1'b0, 1'b1, 2'b00, 2'b00, 0, 0);
    pattern(30, 3, 4);
    phase = "R5 full bypass";
    do_reset(1'b0, 1'b1, 2'b00, 2'b11, 0, 0);
    pattern(30, 3, 4);

    // R6: source routing
    phase = "R6 rise from B, fall from A";
    do_reset(1'b1, 1'b0, 2'b00, 2'b00, 2, 1);
    pattern(60, 9, 7);
    phase = "R6 rise from A, fall from B";
    do_reset(1'b0, 1'b1, 2'b00, 2'b00, 1, 2);
    pattern(60, 7, 9);

    // R7: each polarity code
    for (int p = 0; p < 4; p++) begin
      phase = $sformatf("R7 polarity %0d", p);
      do_reset(1'b0, 1'b0, 2'(p), 2'b00, 1, 2);
      pattern(40, 8, 6);
    end

    // R8: each bypass code
    for (int b = 0; b < 4; b++) begin
      phase = $sformatf("R8 bypass %0d", b);
      do_reset(1'b0, 1'b1, 2'b00, 2'(b), 4, 4);
      pattern(50, 12, 10);
    end

    // R9: gaps without ticks while inputs toggle
    phase = "R9 tick gaps";
    do_reset(1'b0, 1'b0, 2'b00, 2'b00, 3, 3);
    hold(1,1,2); idle(5); hold(1,1,3); idle(4); hold(0,0,2); idle(7);
    hold(0,0,3); idle(3); hold(1,0,8); idle(2); hold(0,1,6);

    // R10: complementary pair with dead band
    phase = "R10 complementary";
    do_reset(1'b0, 1'b0, 2'b10, 2'b00, 2, 3);
    pattern(80, 11, 5);
    hold(1,0,1); hold(0,0,1); hold(1,0,7); hold(0,0,7);

    // R11: largest delay, pulse at and past the limit
    phase = "R11 delay 1023";
    do_reset(1'b0, 1'b0, 2'b00, 2'b00, 1023, 1023);
    hold(1,0,1023); hold(0,0,1023); hold(1,0,1030); hold(0,0,1030);
    hold(0,0,2);

    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule